// File: doc/BRIEF.md
# SPI ADC conversion requester

This block is an SPI master that fetches a single 12-bit conversion from a serial four- or eight-channel analogue-to-digital converter. The clock polarity and phase are both zero. A one-cycle request carries a 3-bit channel number and a flag that picks single-ended or differential input. The block then pulls chip select low and runs one complete frame. During that frame it shifts a command out on MOSI and skips the converter's sampling clock. It checks the null bit and shifts in the twelve result bits, most significant first. The result appears together with a one-cycle done strobe.

The serial clock comes from a divider of the system clock. Each SCK half period is `HALF_DIV` system clocks, so the designer can keep SCK at or below the converter's 2 MHz limit. `BYTE_ALIGN` picks the frame length. The compact frame is 19 clocks. The aligned frame is 24 clocks and puts five zeros ahead of the command, which is the layout a byte-oriented host would see. Requests that arrive while a frame is in progress have no effect.

Top module: `adc_spi_requester`

## Requirements
- R1: During and directly after reset, `cs_n_o` is 1, `sck_o` is 0, `mosi_o` is 0, and `busy_o` and `done_o` are both 0.
- R2: SCK idles low. `sck_o` is never 1 while `cs_n_o` is 1.
- R3: In the compact framing (`BYTE_ALIGN`=0), each accepted request produces exactly 19 SCK rising edges while `cs_n_o` is low.
- R4: MOSI carries the frame bits in this order: the pad zeros (if any), a start bit of 1, then the mode bit (1 = single-ended, 0 = differential), then channel bits 2, 1 and 0, then zeros to the end of the frame. MOSI changes only in the cycle where SCK or chip select falls, so it is stable whenever SCK is high.
- R5: MISO is sampled on SCK rising edges. Counting the start-bit clock as 0, the reading at clock 6 is the null bit. Clocks 7 to 18 carry result bits 11 down to 0. `result_o` holds this value from the `done_o` cycle until the next frame completes. The readings at clock 5 and before the start bit are discarded.
- R6: `null_err_o` is updated together with `done_o`. It is 1 if the null bit read 1 and 0 if it read 0.
- R7: A request is accepted only when `busy_o` is 0. `busy_o` is high from the cycle after acceptance until `done_o` rises. `done_o` is a one-cycle pulse, and exactly one pulse follows each accepted request. A request made while busy starts no frame and does not change the frame in progress.
- R8: Every SCK high and low phase lasts exactly `HALF_DIV` system clocks. From chip select falling to the first SCK rise is `HALF_DIV` clocks, and from the last SCK fall to chip select rising is also `HALF_DIV` clocks.
- R9: In the aligned framing (`BYTE_ALIGN`=1), each frame has 24 SCK rising edges. Five MOSI zeros come before the start bit, which falls on clock 5 of the frame.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request pulse |
| chan_i | input | 3 | Channel number for the request |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 12 | Conversion result |
| null_err_o | output | 1 | Null bit read as 1 |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |

## Verification
The bench builds two instances side by side. The first uses the compact framing with `HALF_DIV`=3, an odd divider. The second uses the aligned framing with `HALF_DIV`=2, an even one. Together they reach both frame lengths and both pad widths, and they check half-period timing at two divider values. Small dividers keep each frame short, so both instances can run every channel code, both modes, boundary result values and injected null errors. A behavioural converter model finds the start bit by itself, so a misplaced command or result window shows up in its captured frame.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
    localparam int RES_W     = 12;
    localparam int CH_W      = 3;
    localparam int PAD_BITS  = 5;
    localparam int CORE_CLKS = 19;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_TAIL
    } phase_e;
endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == LAST);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_spi_pkg::*;
#(
    parameter int FRAME_CLKS = 19,
    parameter int IW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          tick,
    output logic          cs_n,
    output logic          sck,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          rise_stb,
    output logic          fall_stb,
    output logic          finish,
    output logic [IW-1:0] bit_idx
);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_CLKS - 1);

    typedef struct packed {
        phase_e        ph;
        logic          cs_n;
        logic          sck;
        logic          done;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        finish   = 1'b0;
        case (s_q.ph)
            PH_IDLE: if (req) begin
                accept   = 1'b1;
                s_d.ph   = PH_LEAD;
                s_d.cs_n = 1'b0;
                s_d.idx  = '0;
            end
            PH_LEAD, PH_LOW: if (tick) begin
                rise_stb = 1'b1;
                s_d.ph   = PH_HIGH;
                s_d.sck  = 1'b1;
            end
            PH_HIGH: if (tick) begin
                fall_stb = 1'b1;
                s_d.sck  = 1'b0;
                if (s_q.idx == LAST_IDX) begin
                    s_d.ph = PH_TAIL;
                end else begin
                    s_d.ph  = PH_LOW;
                    s_d.idx = s_q.idx + IW'(1);
                end
            end
            PH_TAIL: if (tick) begin
                finish   = 1'b1;
                s_d.ph   = PH_IDLE;
                s_d.cs_n = 1'b1;
                s_d.done = 1'b1;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, cs_n: 1'b1, sck: 1'b0, done: 1'b0, idx: '0};
        else        s_q <= s_d;
    end

    assign cs_n    = s_q.cs_n;
    assign sck     = s_q.sck;
    assign done    = s_q.done;
    assign busy    = (s_q.ph != PH_IDLE);
    assign bit_idx = s_q.idx;

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.idx) < FRAME_CLKS);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    // R2
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sck |-> !s_q.cs_n);
endmodule

// File: rtl/adc_shift_path.sv
module adc_shift_path
    import adc_spi_pkg::*;
#(
    parameter int FRAME_CLKS = 19,
    parameter int PAD        = 0,
    parameter int IW         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CH_W-1:0]  chan,
    input  logic             single,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             finish,
    input  logic [IW-1:0]    bit_idx,
    input  logic             miso,
    output logic             mosi,
    output logic [RES_W-1:0] result,
    output logic             null_err
);
    localparam int START_POS = FRAME_CLKS - 1 - PAD;
    localparam logic [IW-1:0] NULL_IDX  = IW'(PAD + 6);
    localparam logic [IW-1:0] FIRST_RES = IW'(PAD + 7);

    typedef struct packed {
        logic [FRAME_CLKS-1:0] cmd;
        logic [RES_W-1:0]      acc;
        logic                  nul;
        logic [RES_W-1:0]      res;
        logic                  err;
    } path_t;

    path_t p_d, p_q;
    logic [FRAME_CLKS-1:0] fresh;

    always_comb begin
        fresh                        = '0;
        fresh[START_POS]             = 1'b1;
        fresh[START_POS-1]           = single;
        fresh[START_POS-2 -: CH_W]   = chan;

        p_d = p_q;
        if (load)          p_d.cmd = fresh;
        else if (fall_stb) p_d.cmd = p_q.cmd << 1;

        if (rise_stb) begin
            if (bit_idx == NULL_IDX)       p_d.nul = miso;
            else if (bit_idx >= FIRST_RES) p_d.acc = {p_q.acc[RES_W-2:0], miso};
        end

        if (finish) begin
            p_d.res = p_q.acc;
            p_d.err = p_q.nul;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign mosi     = p_q.cmd[FRAME_CLKS-1];
    assign result   = p_q.res;
    assign null_err = p_q.err;

    // R4
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mosi == ((PAD == 0) ? 1'b1 : 1'b0)));
endmodule

// File: rtl/adc_spi_requester.sv
module adc_spi_requester
    import adc_spi_pkg::*;
#(
    parameter int HALF_DIV   = 25,
    parameter bit BYTE_ALIGN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [2:0]       chan_i,
    input  logic             single_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic             null_err_o,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    localparam int PAD        = BYTE_ALIGN ? PAD_BITS : 0;
    localparam int FRAME_CLKS = CORE_CLKS + PAD;
    localparam int IW         = $clog2(FRAME_CLKS);

    logic          tick, accept, rise_stb, fall_stb, finish;
    logic [IW-1:0] bit_idx;

    adc_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy_o), .tick(tick)
    );

    adc_frame_seq #(.FRAME_CLKS(FRAME_CLKS), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req_i), .tick(tick),
        .cs_n(cs_n_o), .sck(sck_o), .busy(busy_o), .done(done_o),
        .accept(accept), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .finish(finish), .bit_idx(bit_idx)
    );

    adc_shift_path #(.FRAME_CLKS(FRAME_CLKS), .PAD(PAD), .IW(IW)) u_path (
        .clk(clk), .rst_n(rst_n), .load(accept), .chan(chan_i),
        .single(single_i), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .finish(finish), .bit_idx(bit_idx), .miso(miso_i),
        .mosi(mosi_o), .result(result_o), .null_err(null_err_o)
    );

    // R4
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> ($fell(sck_o) || $fell(cs_n_o)));
    // R8
    cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (!sck_o && !$past(sck_o)));
    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i));
    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);
endmodule

// File: tb/test_adc_spi_requester.sv
module adc_lane #(
    parameter int HDIV  = 3,
    parameter bit ALIGN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic finished
);
    localparam int OFF  = ALIGN ? 5 : 0;
    localparam int NCLK = 19 + OFF;

    typedef struct {
        logic [11:0] val;
        logic        nul;
        logic [2:0]  ch;
        logic        se;
    } item_t;

    logic        req, single, miso;
    logic [2:0]  chan;
    logic        busy_o, done_o, null_err_o, cs_n_o, sck_o, mosi_o;
    logic [11:0] result_o;

    adc_spi_requester #(.HALF_DIV(HDIV), .BYTE_ALIGN(ALIGN)) i_adc_spi_requester (
        .clk(clk), .rst_n(rst_n), .req_i(req), .chan_i(chan), .single_i(single),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .null_err_o(null_err_o),
        .cs_n_o(cs_n_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso)
    );

    item_t q[$];
    int d_chk = 0, d_fail = 0, m_chk = 0, m_fail = 0;
    int sent = 0, n_done = 0;
    int tim_bad = 0, sck_bad = 0, mosi_bad = 0;
    string fr_tag;
    assign n_chk  = d_chk + m_chk;
    assign n_fail = d_fail + m_fail;

    // converter model
    logic [11:0] adc_val = '0;
    logic        adc_null = 1'b0;
    int          rc = 0, st = -1, last_rc = 0, last_st = -1;
    logic [23:0] cap = '0, last_cap = '0;

    always @(posedge sck_o or negedge cs_n_o) begin
        if (!sck_o) begin
            rc = 0; st = -1; cap = '0;
        end else if (!cs_n_o) begin
            if (rc < 24) cap[rc] = mosi_o;
            if (st < 0 && mosi_o) st = rc;
            rc = rc + 1;
        end
    end

    initial miso = 1'b1;
    always @(negedge sck_o or negedge cs_n_o) begin
        int r;
        r = rc - st;
        if (st < 0)                miso = 1'b1;
        else if (r == 6)           miso = adc_null;
        else if (r >= 7 && r <= 18) miso = adc_val[18 - r];
        else                       miso = 1'b1;
    end

    always @(posedge cs_n_o) begin
        last_rc  = rc;
        last_st  = st;
        last_cap = cap;
    end

    function automatic logic [23:0] exp_frame(logic [2:0] c, logic s);
        logic [23:0] f = '0;
        f[OFF] = 1'b1; f[OFF+1] = s;
        f[OFF+2] = c[2]; f[OFF+3] = c[1]; f[OFF+4] = c[0];
        return f;
    endfunction

    task automatic chk_d(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        d_chk++;
        if (!ok) begin
            d_fail++;
            $display("FAIL %s lane%0d actual=%0h expected=%0h", tag, OFF, act, exp);
        end
    endtask

    task automatic chk_m(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s lane%0d actual=%0h expected=%0h", tag, OFF, act, exp);
        end
    endtask

    // edge timing watcher
    initial begin
        int   gap = 0;
        logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                gap = 0; p_sck = sck_o; p_cs = cs_n_o; p_mosi = mosi_o;
            end else begin
                gap++;
                if (sck_o && cs_n_o) sck_bad++;
                if (mosi_o != p_mosi && sck_o && p_sck) mosi_bad++;
                if (sck_o != p_sck || cs_n_o != p_cs) begin
                    if (!(p_cs && !cs_n_o) && gap != HDIV) tim_bad++;
                    gap = 0;
                end
                p_sck = sck_o; p_cs = cs_n_o; p_mosi = mosi_o;
            end
        end
    end

    // scoreboard monitor
    initial begin
        item_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                n_done++;
                if (q.size() == 0) begin
                    chk_m(1'b0, "R7", 32'(n_done), 32'(sent));
                end else begin
                    e = q.pop_front();
                    chk_m(result_o == e.val, "R5", 32'(result_o), 32'(e.val));
                    chk_m(null_err_o == e.nul, "R6", 32'(null_err_o), 32'(e.nul));
                    chk_m(last_rc == NCLK, fr_tag, 32'(last_rc), 32'(NCLK));
                    chk_m(last_cap == exp_frame(e.ch, e.se), "R4", 32'(last_cap), 32'(exp_frame(e.ch, e.se)));
                    chk_m(last_st == OFF, ALIGN ? "R9" : "R4", 32'(last_st), 32'(OFF));
                    chk_m(busy_o == 1'b0, "R7", 32'(busy_o), 32'd0);
                    chk_m(tim_bad == 0, "R8", 32'(tim_bad), 32'd0);
                    chk_m(sck_bad == 0, "R2", 32'(sck_bad), 32'd0);
                    chk_m(mosi_bad == 0, "R4", 32'(mosi_bad), 32'd0);
                end
            end
        end
    end

    task automatic send(input logic [2:0] c, input logic s, input logic [11:0] v,
                        input logic nv, input bit dup);
        while (busy_o) @(negedge clk);
        adc_val  = v;
        adc_null = nv;
        q.push_back('{val: v, nul: nv, ch: c, se: s});
        sent++;
        chan = c; single = s; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk_d(busy_o == 1'b1, "R7", 32'(busy_o), 32'd1);
        if (dup) begin
            repeat (3) @(negedge clk);
            chan = ~c; single = ~s; req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk_d(busy_o == 1'b1, "R7", 32'(busy_o), 32'd1);
        end
    endtask

    initial begin
        fr_tag   = ALIGN ? "R9" : "R3";
        finished = 1'b0;
        req = 1'b1; chan = 3'd3; single = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state with a request held during reset
        chk_d(cs_n_o == 1'b1, "R1", 32'(cs_n_o), 32'd1);
        chk_d(sck_o == 1'b0, "R1", 32'(sck_o), 32'd0);
        chk_d(mosi_o == 1'b0, "R1", 32'(mosi_o), 32'd0);
        chk_d(busy_o == 1'b0 && done_o == 1'b0, "R1", 32'({busy_o, done_o}), 32'd0);
        req = 1'b0;
        while (!rst_n) @(negedge clk);
        @(negedge clk);
        chk_d(cs_n_o == 1'b1 && busy_o == 1'b0, "R1", 32'({cs_n_o, busy_o}), 32'd2);

        send(3'd0, 1'b1, 12'hABC, 1'b0, 1'b0);
        send(3'd7, 1'b0, 12'h001, 1'b0, 1'b0);
        send(3'd5, 1'b1, 12'h800, 1'b0, 1'b1);
        send(3'd3, 1'b1, 12'hFFF, 1'b0, 1'b0);
        send(3'd2, 1'b0, 12'h000, 1'b1, 1'b0);
        send(3'd6, 1'b1, 12'h5A5, 1'b0, 1'b1);
        send(3'd1, 1'b1, 12'h3C3, 1'b1, 1'b0);
        send(3'd4, 1'b0, 12'h7FE, 1'b0, 1'b0);
        for (int c = 0; c < 8; c++) begin
            send(3'(c), c[0], 12'(c * 291 + 17), 1'b0, (c == 4));
        end

        while (q.size() != 0 || busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        // R7 one done pulse per accepted request, extra requests ignored
        chk_d(n_done == sent, "R7", 32'(n_done), 32'(sent));
        finished = 1'b1;
    end
endmodule

module test_adc_spi_requester;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c_chk, c_fail, a_chk, a_fail;
    logic c_fin, a_fin;

    always #5 clk = ~clk;

    adc_lane #(.HDIV(3), .ALIGN(1'b0)) u_lane_compact (
        .clk(clk), .rst_n(rst_n), .n_chk(c_chk), .n_fail(c_fail), .finished(c_fin)
    );
    adc_lane #(.HDIV(2), .ALIGN(1'b1)) u_lane_aligned (
        .clk(clk), .rst_n(rst_n), .n_chk(a_chk), .n_fail(a_fail), .finished(a_fin)
    );

    initial begin
        repeat (6) @(posedge clk);
        rst_n = 1'b1;
    end

    initial begin
        int cyc = 0;
        int wd  = 0;
        while (!(c_fin === 1'b1 && a_fin === 1'b1) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 100000) begin
            wd = 1;
            $display("FAIL watchdog run did not complete actual=%0d expected<%0d", cyc, 100000);
        end
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", c_chk + a_chk + wd, c_fail + a_fail + wd);
        $finish;
    end
endmodule